// File: doc/BRIEF.md
# Floating Compare Condition-Code Unit

This block compares two IEEE-754 values and records the outcome as a 2-bit condition code in a 64-bit floating-point status word. A precision input picks 32-bit or 64-bit operands. A 2-bit selector chooses which of four condition-code fields receives the code. An unordered result comes from a NaN on either side. It either raises a trap request or records a sticky invalid flag. Which one happens depends on a mode input (plain or signalling compare) and on the invalid trap-enable bit in the incoming status word.

The caller presents the operands, the controls and the present status word, and pulses `valid_i`. On the next clock edge the unit registers the updated status word and, when a trap applies, a one-cycle trap strobe. The caller writes the updated word back to its status register and hands the trap to whatever services it.

Top module: `fcmp_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `status_o` is all zeros and `trap_o` is 0.
- R2: Ordered results are encoded in the selected field as 2'b00 for a == b, 2'b01 for a < b and 2'b10 for a > b. +0 and -0 compare equal, and negative values order below positive ones.
- R3: An operand whose exponent is all ones and whose fraction is nonzero is a NaN, and the field gets 2'b11. An infinity (all-ones exponent, zero fraction) is ordered and larger than every finite value of its sign.
- R4: Selector value 0 writes status bits 11:10, and values 1, 2 and 3 write bits 33:32, 35:34 and 37:36. The old contents of the field are replaced. Every bit not named in R4, R6 or R7 passes through from `status_i` unchanged.
- R5: With `dbl_i` = 0 only bits 31:0 of each operand take part (sign 31, exponent 30:23, fraction 22:0), and bits 63:32 are ignored. With `dbl_i` = 1 all 64 bits take part (sign 63, exponent 62:52, fraction 51:0).
- R6: An unordered result traps when `signal_i` = 1 or status bit 27 (invalid trap enable) is 1. A trap sets the current-invalid bit 4, writes 3'b001 into the trap-type field 16:14, and raises `trap_o`.
- R7: An unordered result that does not trap sets the accrued-invalid bit 9. It leaves bits 4 and 16:14 as they came in, and `trap_o` stays 0.
- R8: An ordered result never traps and changes none of bits 4, 9 and 16:14, in either the plain or the signalling mode.
- R9: Results are captured on the rising edge where `valid_i` = 1 and appear on the outputs during the following cycle. While `valid_i` = 0, `status_o` holds its value and `trap_o` is 0, so a trap is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Capture strobe for one compare |
| dbl_i | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits 31:0 |
| fld_sel_i | input | 2 | Target condition-code field |
| signal_i | input | 1 | 1 = signalling compare (any unordered result traps) |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| status_i | input | 64 | Present status word |
| status_o | output | 64 | Updated status word, registered |
| trap_o | output | 1 | Trap request pulse, registered |

## Verification
Faults in this block's internal state are visible on the first output cycle after the capture edge. A wrong operand class or wrong magnitude order shows as a bad 2-bit code in the selected field. A wrong field offset shows as a changed field that should have passed through. A wrong trap decision shows up at once, and always together: `trap_o`, bit 4 and field 16:14 on one side, bit 9 on the other. A capture register that ignores `valid_i` makes `status_o` move during idle cycles. A trap register that holds its value stretches the pulse into a second cycle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int STAT_W      = 64;
    localparam int MAG_W       = 63;
    localparam int CC_W        = 2;
    localparam int CC_BASE     = 10;
    localparam int CC_HI_SHIFT = 22;
    localparam int NV_TEM_BIT  = 27;
    localparam int NV_ACC_BIT  = 9;
    localparam int NV_CUR_BIT  = 4;
    localparam int TT_LSB      = 14;
    localparam int TT_W        = 3;
    localparam logic [TT_W-1:0] TT_IEEE = 3'b001;

    localparam int SP_EXP = 8;
    localparam int SP_FRC = 23;
    localparam int DP_EXP = 11;
    localparam int DP_FRC = 52;

    typedef enum logic [CC_W-1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             zero;
    } opnd_t;

    function automatic int cc_lsb(input logic [1:0] sel);
        if (sel == 2'd0)
            return CC_BASE;
        return CC_BASE + CC_HI_SHIFT + 2 * (int'(sel) - 1);
    endfunction

    function automatic logic [CC_W-1:0] cc_get(input logic [STAT_W-1:0] s,
                                               input logic [1:0] sel);
        return s[cc_lsb(sel) +: CC_W];
    endfunction

endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int FRC_W = 23
) (
    input  logic [EXP_W+FRC_W:0] word_i,
    output opnd_t                info_o
);
    localparam int W = EXP_W + FRC_W + 1;

    logic [EXP_W-1:0] expo;
    logic [FRC_W-1:0] frac;

    assign expo = word_i[W-2:FRC_W];
    assign frac = word_i[FRC_W-1:0];

    always_comb begin
        info_o      = '0;
        info_o.sign = word_i[W-1];
        info_o.mag  = MAG_W'(word_i[W-2:0]);
        info_o.nan  = (&expo) && (|frac);
        info_o.zero = ~|word_i[W-2:0];
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_e  rel_o
);
    logic mag_lt;

    assign mag_lt = a_i.mag < b_i.mag;

    always_comb begin
        if (a_i.nan || b_i.nan)
            rel_o = REL_UN;
        else if (a_i.zero && b_i.zero)
            rel_o = REL_EQ;
        else if (a_i.sign != b_i.sign)
            rel_o = a_i.sign ? REL_LT : REL_GT;
        else if (a_i.mag == b_i.mag)
            rel_o = REL_EQ;
        else if (!a_i.sign)
            rel_o = mag_lt ? REL_LT : REL_GT;
        else
            rel_o = mag_lt ? REL_GT : REL_LT;
    end
endmodule

// File: rtl/fcmp_status_merge.sv
module fcmp_status_merge
    import fcmp_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    input  logic [1:0]        sel_i,
    input  rel_e              rel_i,
    input  logic              signal_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              trap_o
);
    logic unord;

    assign unord  = (rel_i == REL_UN);
    assign trap_o = unord && (signal_i || stat_i[NV_TEM_BIT]);

    always_comb begin
        stat_o = stat_i;
        stat_o[cc_lsb(sel_i) +: CC_W] = rel_i;
        if (trap_o) begin
            stat_o[NV_CUR_BIT]         = 1'b1;
            stat_o[TT_LSB +: TT_W]     = TT_IEEE;
        end else if (unord) begin
            stat_o[NV_ACC_BIT]         = 1'b1;
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              dbl_i,
    input  logic [1:0]        fld_sel_i,
    input  logic              signal_i,
    input  logic [63:0]       op_a_i,
    input  logic [63:0]       op_b_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [STAT_W-1:0] status_o,
    output logic              trap_o
);
    localparam int N_OPS = 2;
    localparam int SP_W  = SP_EXP + SP_FRC + 1;
    localparam int DP_W  = DP_EXP + DP_FRC + 1;

    logic [63:0]       words [N_OPS];
    opnd_t             sp_info [N_OPS];
    opnd_t             dp_info [N_OPS];
    opnd_t             sel_info [N_OPS];
    rel_e              rel;
    logic [STAT_W-1:0] status_n;
    logic              trap_n;
    logic [STAT_W-1:0] status_q;
    logic              trap_q;

    assign words[0] = op_a_i;
    assign words[1] = op_b_i;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_op
        fcmp_unpack #(.EXP_W(SP_EXP), .FRC_W(SP_FRC)) u_sp (
            .word_i (words[gi][SP_W-1:0]),
            .info_o (sp_info[gi])
        );
        fcmp_unpack #(.EXP_W(DP_EXP), .FRC_W(DP_FRC)) u_dp (
            .word_i (words[gi][DP_W-1:0]),
            .info_o (dp_info[gi])
        );
        assign sel_info[gi] = dbl_i ? dp_info[gi] : sp_info[gi];
    end

    fcmp_relate u_rel (
        .a_i   (sel_info[0]),
        .b_i   (sel_info[1]),
        .rel_o (rel)
    );

    fcmp_status_merge u_merge (
        .stat_i   (status_i),
        .sel_i    (fld_sel_i),
        .rel_i    (rel),
        .signal_i (signal_i),
        .stat_o   (status_n),
        .trap_o   (trap_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            trap_q   <= 1'b0;
        end else begin
            trap_q <= valid_i && trap_n;
            if (valid_i)
                status_q <= status_n;
        end
    end

    assign status_o = status_q;
    assign trap_o   = trap_q;
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker
    import fcmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [1:0]        fld_sel_i,
    input logic              signal_i,
    input logic [STAT_W-1:0] status_i,
    input logic [STAT_W-1:0] status_o,
    input logic              trap_o
);
    p_trap_after_valid_r9: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past(valid_i));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(valid_i) && !$past(rst)) |-> $stable(status_o));

    p_trap_marks_r6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (status_o[NV_CUR_BIT]
                    && status_o[TT_LSB +: TT_W] == TT_IEEE
                    && cc_get(status_o, $past(fld_sel_i)) == 2'b11));

    p_signal_unord_traps_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && !$past(rst) && $past(signal_i) && !trap_o)
            |-> cc_get(status_o, $past(fld_sel_i)) != 2'b11);

    p_no_trap_keeps_type_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && !$past(rst) && !trap_o)
            |-> (status_o[TT_LSB +: TT_W] == $past(status_i[TT_LSB +: TT_W])
                 && status_o[NV_CUR_BIT] == $past(status_i[NV_CUR_BIT])));
endmodule

bind fcmp_unit fcmp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .fld_sel_i (fld_sel_i),
    .signal_i  (signal_i),
    .status_i  (status_i),
    .status_o  (status_o),
    .trap_o    (trap_o)
);

// File: tb/fcmp_unit_test.sv
`timescale 1ns/1ps
module fcmp_unit_test;

    typedef struct packed {
        logic        dbl;
        logic [1:0]  sel;
        logic        sig;
        logic        tem;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  code;
        logic        trap;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h3F800000, 64'h40000000, 2'b01, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b0, 64'h40000000, 64'h3F800000, 2'b10, 1'b0},
        '{1'b0, 2'd2, 1'b0, 1'b0, 64'h00000000, 64'h80000000, 2'b00, 1'b0},
        '{1'b0, 2'd3, 1'b0, 1'b0, 64'hBF800000, 64'h3F800000, 2'b01, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'hBF800000, 64'hC0000000, 2'b10, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 64'h7FC00000, 64'h3F800000, 2'b11, 1'b0},
        '{1'b0, 2'd1, 1'b1, 1'b0, 64'h3F800000, 64'h7FC00000, 2'b11, 1'b1},
        '{1'b0, 2'd2, 1'b0, 1'b1, 64'h7F800001, 64'h3F800000, 2'b11, 1'b1},
        '{1'b0, 2'd3, 1'b0, 1'b0, 64'h7F800000, 64'h3F800000, 2'b10, 1'b0},
        '{1'b1, 2'd3, 1'b0, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, 2'b01, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'hC000000000000000, 64'h3FF0000000000000, 2'b01, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 64'h7FF8000000000000, 64'h3FF0000000000000, 2'b11, 1'b0},
        '{1'b1, 2'd2, 1'b0, 1'b0, 64'h8000000000000000, 64'h0000000000000000, 2'b00, 1'b0},
        '{1'b1, 2'd0, 1'b1, 1'b1, 64'h3FF0000000000000, 64'h3FF0000000000000, 2'b00, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b0, 64'hDEADBEEF3F800000, 64'h7FF0000140000000, 2'b01, 1'b0},
        '{1'b1, 2'd3, 1'b1, 1'b0, 64'h7FF0000000000001, 64'h0000000000000000, 2'b11, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [1:0]  fld_sel_i = '0;
    logic        signal_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [63:0] status_i = '0;
    logic [63:0] status_o;
    logic        trap_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fcmp_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .dbl_i(dbl_i),
        .fld_sel_i(fld_sel_i), .signal_i(signal_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .status_i(status_i), .status_o(status_o),
        .trap_o(trap_o)
    );

    function automatic int lsb_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 10;
            2'd1:    return 32;
            2'd2:    return 34;
            default: return 36;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [63:0] s, input logic [1:0] sel,
                                          input logic [1:0] code, input logic trap);
        logic [63:0] r = s;
        r[lsb_of(sel) +: 2] = code;
        if (trap) begin
            r[4] = 1'b1;
            r[16:14] = 3'b001;
        end else if (code == 2'b11) begin
            r[9] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] base, held;
        repeat (3) @(negedge clk);
        chk("R1 reset status", status_o, 64'h0);
        chk("R1 reset trap", 64'(trap_o), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset status", status_o, 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            base = 64'hF0F0_0FFF_3C30_CCEF ^ (64'(i) << 48);
            base[27] = v.tem;
            dbl_i = v.dbl; fld_sel_i = v.sel; signal_i = v.sig;
            op_a_i = v.a; op_b_i = v.b; status_i = base;
            valid_i = 1'b1;
            @(negedge clk);
            valid_i = 1'b0;
            // R2 R3 R4 R5 R6 R7 R8: whole status word against the model
            chk($sformatf("R2-code/R4 vector %0d status", i), status_o,
                model(base, v.sel, v.code, v.trap));
            chk($sformatf("R6 vector %0d trap", i), 64'(trap_o), 64'(v.trap));
            held = status_o;
            status_i = ~base;
            @(negedge clk);
            chk($sformatf("R9 vector %0d pulse end", i), 64'(trap_o), 64'h0);
            chk($sformatf("R9 vector %0d hold", i), status_o, held);
        end

        // R9: inputs that would trap, but no strobe
        held = status_o;
        dbl_i = 1'b0; signal_i = 1'b1; op_a_i = 64'h7FC00000; status_i = 64'h0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 idle no trap", 64'(trap_o), 64'h0);
        chk("R9 idle hold", status_o, held);

        // R7 with every other bit clear
        signal_i = 1'b0; fld_sel_i = 2'd2; status_i = 64'h0; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R7 accrued only", status_o, 64'h0000_000C_0000_0200);

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run reset", status_o, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule